// File: doc/BRIEF.md
# Indirect Dword Register Window

This block is an 8-byte configuration window that gives access to a larger register file one dword at a time. Software writes a select byte to choose a dword. It then reads the window's data dword to see that dword's contents, or writes the data dword to change it. The register file stays outside the block. The window drives one dword address to it and receives, for that dword, the stored data, a per-bit write mask and a per-bit write-one-to-clear mask. When a forwarded write is due, the window returns the merged bytes together with byte strobes.

Each window write that touches at least one byte schedules a refresh. In the next cycle the data dword is reloaded from the register-file dword at select times four. If the write covered any byte of the data dword, the forwarded write is issued in that same cycle, and the refresh picks up its result. The register file has a fixed size. Bytes at or past its end are never written and read back as zero.

Top module: `regwin_indirect`

## Requirements
- R1: After reset the select byte and the data dword read 0. Byte 0 of the window reads the HDR_ID parameter, byte 1 reads HDR_NEXT, and the status byte reads 0.
- R2: Window byte 3 is the status byte. It always reads 0, and writes to it have no effect. Writes to bytes 0 and 1 also have no effect. A read with `cfg_dw`=0 returns {status, select, HDR_NEXT, HDR_ID}, with HDR_ID in bits 7:0.
- R3: Window byte 2 is the select byte, in bits 23:16 of dword 0. It is fully writable under `cfg_be[2]`.
- R4: A write to dword 1 (`cfg_dw`=1) stores each enabled byte into the data dword. In the cycle right after the write edge, a read returns that stored value, which is the value before the reload.
- R5: A write with `cfg_dw`=1 and any byte enable set forwards the whole data dword in the next cycle, as one write to register-file address select*4.
- R6: Each forwarded byte is written as ((old AND NOT wmask) OR (new AND wmask)) AND NOT (new AND w1cmask). No bit is set in both masks.
- R7: Only register-file bytes below RF_BYTES are written. Past that point, reload bytes read 0. A dword that crosses the end is truncated, and a dword that lies wholly past the end is not written at all.
- R8: Any write with a nonzero byte enable reloads the data dword from address select*4, and the new value is visible from the second cycle after the write edge. With no such write, the data dword holds even if the register file changes.
- R9: When two writes come on consecutive cycles, the bytes of the second write take precedence over the reload due from the first. The result matches applying the two writes one after the other.
- R10: `rf_addr` always equals the current select value times four.
- R11: Byte k of the data dword maps to register-file address select*4+k and to strobe bit k, in little-endian order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Window write strobe |
| cfg_dw | input | 1 | Window dword: 0 = header/select/status, 1 = data |
| cfg_be | input | 4 | Byte enables of the window write |
| cfg_wdata | input | 32 | Window write data |
| cfg_rdata | output | 32 | Window read data for the dword chosen by cfg_dw |
| rf_addr | output | SEL_W+2 | Register-file byte address of the selected dword |
| rf_rd_data | input | 32 | Register-file contents at rf_addr |
| rf_rd_wmask | input | 32 | Write mask at rf_addr |
| rf_rd_w1cmask | input | 32 | Write-one-to-clear mask at rf_addr |
| rf_wr_en | output | 1 | Forwarded write strobe |
| rf_wr_be | output | 4 | Byte strobes of the forwarded write |
| rf_wr_data | output | 32 | Merged bytes to store at rf_addr |

## Verification
Two activities can land in the same cycle. One is a new window write. The other is the reload, plus the forwarded write, that is still due from the write before it. The bench provokes this with back-to-back writes, including a pair in which the first changes the select byte and the second writes the data dword. It judges the outcome against a model that applies the two writes strictly in sequence. The bench also compares the register-file copy byte by byte, and it checks that the value read in the cycle between a write and its reload is still the pre-reload value.

// File: rtl/regwin_indirect.sv
module regwin_indirect #(
  parameter int         RF_BYTES = 42,
  parameter int         SEL_W    = 8,
  parameter logic [7:0] HDR_ID   = 8'h0C,
  parameter logic [7:0] HDR_NEXT = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_dw,
  input  logic [3:0]         cfg_be,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  output logic [SEL_W+1:0]   rf_addr,
  input  logic [31:0]        rf_rd_data,
  input  logic [31:0]        rf_rd_wmask,
  input  logic [31:0]        rf_rd_w1cmask,
  output logic               rf_wr_en,
  output logic [3:0]         rf_wr_be,
  output logic [31:0]        rf_wr_data
);
  localparam int          AW     = SEL_W + 2;
  localparam logic [31:0] RF_END = 32'(RF_BYTES);

  logic [SEL_W-1:0] sel_q;
  logic [31:0]      data_q;
  logic             pend_q;
  logic             fwd_q;
  logic [3:0]       in_rng;
  logic [31:0]      merged;
  logic [31:0]      reload;
  logic             wr_hit;

  assign wr_hit  = cfg_we && (cfg_be != 4'b0000);
  assign rf_addr = {sel_q, 2'b00};

  for (genvar k = 0; k < 4; k++) begin : g_byte
    logic [7:0] old_b, new_b, wm_b, wc_b;
    assign old_b = rf_rd_data[8*k +: 8];
    assign new_b = data_q[8*k +: 8];
    assign wm_b  = rf_rd_wmask[8*k +: 8];
    assign wc_b  = rf_rd_w1cmask[8*k +: 8];
    assign in_rng[k] = (32'(rf_addr) + 32'(k)) < RF_END;
    assign merged[8*k +: 8] = ((old_b & ~wm_b) | (new_b & wm_b)) & ~(new_b & wc_b);
    assign reload[8*k +: 8] = !in_rng[k] ? 8'h00 : (fwd_q ? merged[8*k +: 8] : old_b);
  end

  assign rf_wr_en   = pend_q && fwd_q && in_rng[0];
  assign rf_wr_be   = (pend_q && fwd_q) ? in_rng : 4'b0000;
  assign rf_wr_data = merged;

  assign cfg_rdata = cfg_dw ? data_q : {8'h00, 8'(sel_q), HDR_NEXT, HDR_ID};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      data_q <= '0;
      pend_q <= 1'b0;
      fwd_q  <= 1'b0;
    end else begin
      pend_q <= wr_hit;
      fwd_q  <= wr_hit && cfg_dw;
      if (wr_hit && !cfg_dw && cfg_be[2])
        sel_q <= cfg_wdata[16 +: SEL_W];
      for (int k = 0; k < 4; k++) begin
        if (wr_hit && cfg_dw && cfg_be[k])
          data_q[8*k +: 8] <= cfg_wdata[8*k +: 8];
        else if (pend_q)
          data_q[8*k +: 8] <= reload[8*k +: 8];
      end
    end
  end
endmodule

module regwin_indirect_chk #(
  parameter int RF_BYTES = 42,
  parameter int SEL_W    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             cfg_dw,
  input logic [3:0]       cfg_be,
  input logic [31:0]      cfg_wdata,
  input logic [31:0]      cfg_rdata,
  input logic [SEL_W+1:0] rf_addr,
  input logic [31:0]      rf_rd_wmask,
  input logic [31:0]      rf_rd_w1cmask,
  input logic             rf_wr_en,
  input logic [3:0]       rf_wr_be,
  input logic [31:0]      data_q,
  input logic             pend_q
);
  localparam logic [31:0] RF_END = 32'(RF_BYTES);

  a_r2_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dw |-> cfg_rdata[31:24] == 8'h00);

  a_r10_select_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_dw && cfg_be[2]) |=> rf_addr[SEL_W+1:2] == $past(cfg_wdata[16 +: SEL_W]));

  a_r4_data_store: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_dw && cfg_be[0]) |=> data_q[7:0] == $past(cfg_wdata[7:0]));

  a_r5_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_dw && cfg_be != 4'b0000) |=> rf_wr_en == (32'(rf_addr) < RF_END));

  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_be != 4'b0000) |=> !rf_wr_en);

  a_r7_truncate: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr_en && rf_wr_be[3]) |-> (32'(rf_addr) + 32'd3) < RF_END);

  a_r6_mask_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> (rf_rd_wmask & rf_rd_w1cmask) == 32'h0);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cfg_we && cfg_be != 4'b0000) && !pend_q) |=> $stable(data_q));
endmodule

bind regwin_indirect regwin_indirect_chk #(.RF_BYTES(RF_BYTES), .SEL_W(SEL_W)) chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rf_addr(rf_addr),
  .rf_rd_wmask(rf_rd_wmask), .rf_rd_w1cmask(rf_rd_w1cmask), .rf_wr_en(rf_wr_en),
  .rf_wr_be(rf_wr_be), .data_q(data_q), .pend_q(pend_q));

// File: tb/regwin_indirect_test.sv
module regwin_indirect_test;
  localparam int RFB = 42;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_dw = 1'b0;
  logic [3:0]  cfg_be = 4'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic [9:0]  rf_addr;
  logic [31:0] rf_rd_data, rf_rd_wmask, rf_rd_w1cmask;
  logic        rf_wr_en;
  logic [3:0]  rf_wr_be;
  logic [31:0] rf_wr_data;

  logic [7:0] mem [0:1023];
  logic [7:0] wm  [0:1023];
  logic [7:0] wc  [0:1023];
  logic [7:0] emem [0:1023];
  logic       poke = 1'b0;
  logic [9:0] poke_a = '0;
  logic [7:0] poke_v = '0;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0]  m_sel = 8'h00;
  logic [31:0] m_data = 32'h0;

  always #10 clk = ~clk;

  regwin_indirect #(.RF_BYTES(RFB), .SEL_W(8), .HDR_ID(8'h0C), .HDR_NEXT(8'h00)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rf_addr(rf_addr),
    .rf_rd_data(rf_rd_data), .rf_rd_wmask(rf_rd_wmask), .rf_rd_w1cmask(rf_rd_w1cmask),
    .rf_wr_en(rf_wr_en), .rf_wr_be(rf_wr_be), .rf_wr_data(rf_wr_data));

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      rf_rd_data[8*k +: 8]    = mem[rf_addr + 10'(k)];
      rf_rd_wmask[8*k +: 8]   = wm[rf_addr + 10'(k)];
      rf_rd_w1cmask[8*k +: 8] = wc[rf_addr + 10'(k)];
    end
  end

  always @(posedge clk) begin
    if (poke) mem[poke_a] <= poke_v;
    if (rf_wr_en)
      for (int k = 0; k < 4; k++)
        if (rf_wr_be[k]) mem[rf_addr + 10'(k)] <= rf_wr_data[8*k +: 8];
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] merge(input logic [7:0] o, input logic [7:0] n,
                                       input logic [7:0] m, input logic [7:0] c);
    return ((o & ~m) | (n & m)) & ~(n & c);
  endfunction

  // model: applies one window write sequentially, returns the pre-reload data value
  task automatic mwrite(input bit dw, input logic [3:0] be, input logic [31:0] wd,
                        output logic [31:0] raw);
    if (be != 4'h0) begin
      if (!dw && be[2]) m_sel = wd[23:16];
      if (dw)
        for (int k = 0; k < 4; k++) if (be[k]) m_data[8*k +: 8] = wd[8*k +: 8];
      raw = m_data;
      if (dw)
        for (int k = 0; k < 4; k++) begin
          int a = int'(m_sel) * 4 + k;
          if (a < RFB) emem[a] = merge(emem[a], m_data[8*k +: 8], wm[a], wc[a]);
        end
      for (int k = 0; k < 4; k++) begin
        int a = int'(m_sel) * 4 + k;
        m_data[8*k +: 8] = (a < RFB) ? emem[a] : 8'h00;
      end
    end else raw = m_data;
  endtask

  task automatic drive(input bit dw, input logic [3:0] be, input logic [31:0] wd);
    cfg_we = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = wd;
  endtask

  task automatic compare_all(input string tag);
    bit ok = 1;
    int bad = 0;
    cfg_dw = 1'b1; #1;
    check(cfg_rdata == m_data, {tag, " R8 data"}, cfg_rdata, m_data);
    cfg_dw = 1'b0; #1;
    check(cfg_rdata == {8'h00, m_sel, 8'h00, 8'h0C}, {tag, " R2 R3 dword0"}, cfg_rdata,
          {8'h00, m_sel, 8'h00, 8'h0C});
    for (int a = 0; a < 1024; a++) if (mem[a] !== emem[a]) begin ok = 0; bad = a; end
    check(ok, {tag, " R6 R7 R11 file"}, {24'h0, mem[bad]}, {24'h0, emem[bad]});
    check(rf_addr == {m_sel, 2'b00}, {tag, " R10 addr"}, {22'h0, rf_addr}, {22'h0, m_sel, 2'b00});
  endtask

  task automatic one_write(input bit dw, input logic [3:0] be, input logic [31:0] wd, input string tag);
    logic [31:0] raw;
    @(negedge clk); drive(dw, be, wd);
    mwrite(dw, be, wd, raw);
    @(negedge clk); cfg_we = 1'b0; cfg_dw = 1'b1; #1;
    check(cfg_rdata == raw, {tag, " R4 pre-reload"}, cfg_rdata, raw);
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    for (int a = 0; a < 1024; a++) begin
      logic [7:0] m;
      m = 8'($urandom);
      mem[a] = 8'($urandom);
      emem[a] = mem[a];
      wm[a] = m;
      wc[a] = 8'($urandom) & ~m;
    end
    repeat (3) @(negedge clk);
    cfg_dw = 1'b1; #1;
    check(cfg_rdata == 32'h0, "R1 reset data", cfg_rdata, 32'h0);
    cfg_dw = 1'b0; #1;
    check(cfg_rdata == 32'h0000_000C, "R1 reset dword0", cfg_rdata, 32'h0000_000C);
    rst_n = 1'b1;

    one_write(1'b0, 4'b1011, 32'hFFFF_FFFF, "status/header ignored");
    one_write(1'b0, 4'b0100, 32'h0003_0000, "select 3");
    one_write(1'b1, 4'b1111, 32'hA5C3_0FF0, "full data write");
    one_write(1'b1, 4'b0010, 32'h0000_7E00, "single byte R11");
    one_write(1'b0, 4'b0100, 32'h000A_0000, "select 10 R7");
    one_write(1'b1, 4'b1111, 32'hFFFF_FFFF, "truncated R7");
    one_write(1'b0, 4'b0100, 32'h00C8_0000, "select 200 R7");
    one_write(1'b1, 4'b1111, 32'h1234_5678, "beyond end R7");
    one_write(1'b0, 4'b0100, 32'h0001_0000, "select 1");

    // R8: file changes without a window write are not seen
    @(negedge clk); poke = 1'b1; poke_a = 10'd4; poke_v = ~mem[4];
    @(negedge clk); poke = 1'b0; emem[4] = poke_v;
    @(negedge clk); cfg_dw = 1'b1; #1;
    check(cfg_rdata == m_data, "R8 stale mirror holds", cfg_rdata, m_data);
    one_write(1'b0, 4'b1000, 32'h0, "status touch reloads R8");

    // R9: back-to-back, select change then data write
    begin
      logic [31:0] raw;
      @(negedge clk); drive(1'b0, 4'b0100, 32'h0005_0000); mwrite(1'b0, 4'b0100, 32'h0005_0000, raw);
      @(negedge clk); drive(1'b1, 4'b0101, 32'h00EE_00DD); mwrite(1'b1, 4'b0101, 32'h00EE_00DD, raw);
      @(negedge clk); cfg_we = 1'b0;
      @(negedge clk); compare_all("R9 back-to-back");
      @(negedge clk); drive(1'b1, 4'b1111, 32'h0F0F_0F0F); mwrite(1'b1, 4'b1111, 32'h0F0F_0F0F, raw);
      @(negedge clk); drive(1'b1, 4'b1000, 32'hAB00_0000); mwrite(1'b1, 4'b1000, 32'hAB00_0000, raw);
      @(negedge clk); cfg_we = 1'b0;
      @(negedge clk); compare_all("R9 two data writes");
    end

    for (int i = 0; i < 300; i++) begin
      bit dw;
      logic [3:0] be;
      logic [31:0] wd;
      dw = 1'($urandom);
      be = 4'($urandom);
      wd = $urandom;
      if (!dw && ($urandom % 8 != 0)) wd[23:16] = 8'($urandom % 12);
      if (($urandom % 4) == 0) begin
        logic [31:0] raw;
        @(negedge clk); drive(dw, be, wd); mwrite(dw, be, wd, raw);
        @(negedge clk); drive(1'b1, 4'($urandom), $urandom);
        mwrite(1'b1, cfg_be, cfg_wdata, raw);
        @(negedge clk); cfg_we = 1'b0;
        @(negedge clk); compare_all("R9 random pair");
      end else
        one_write(dw, be, wd, "random R5");
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule